// File: doc/BRIEF.md
# Two-Port RAM with Mailbox Doorbells

This block is a two-port memory of 9-bit words in which two sides, left and right, each have their own enable, write select, output enable, address and data. Either side can read or write any word at any time. The two highest addresses also work as doorbells. When one side writes the mailbox that faces the other side, the other side's active-low interrupt output goes low. It stays low until the receiving side accesses that mailbox with output enable active.

The mailbox words stay ordinary storage. The ringing side leaves a message there, and the receiving side reads the message back in the same access that acknowledges the doorbell. A system that never uses the doorbells can treat those two words as plain RAM. Each side also has a busy input. While it is high, that side's writes are dropped and its accesses have no effect on either interrupt flag. The block is fully synchronous, and its reads are registered.

Top module: `mbox_dpram`

## Requirements
- R1: While reset is low, both interrupt outputs are driven high and both read-data outputs are zero.
- R2: A side writes a word when its enable and write select are high and its busy input is low. When enable and output enable are high and write select is low, the addressed word appears on that side's read data one cycle later. In every other cycle the read data keeps its value.
- R3: A right-side write (enable high, write select high, busy low) to the address one below the top drives `l_irq_n` low from the next cycle. A left-side write to that same address leaves `l_irq_n` unchanged.
- R4: A left-side access to the address one below the top, with enable and output enable high and busy low, drives `l_irq_n` high from the next cycle. The level of write select does not matter for this. With output enable low, the access does not clear the flag.
- R5: A left-side write to the top address drives `r_irq_n` low from the next cycle. A right-side access to the top address with enable and output enable high and busy low drives it high again. A right-side write to the top address does not set `r_irq_n`.
- R6: The two mailbox words hold whatever was last written to them, and the receiving side reads that message back.
- R7: When a side's busy input is high, its write neither stores data nor sets the other side's flag. Its access does not clear its own flag.
- R8: If a set and a clear of the same flag happen in the same cycle, the flag ends up set (output low).
- R9: A flag with no set and no clear in a cycle keeps its level.
- R10: When both sides write the same word in the same cycle, the right side's data is the one stored.
- R11: A read of a word that the other side writes in the same cycle returns the word's previous content.
- R12: The top address is all ones in `ADDR_W` bits (255 at the default width of 8). The left mailbox is that value minus one (254).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_en | input | 1 | Left side enable |
| l_wr | input | 1 | Left write select (1 = write) |
| l_oe | input | 1 | Left output enable |
| l_busy | input | 1 | Left busy; blocks writes and flag actions |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left registered read data |
| l_irq_n | output | 1 | Left doorbell, active low |
| r_en | input | 1 | Right side enable |
| r_wr | input | 1 | Right write select (1 = write) |
| r_oe | input | 1 | Right output enable |
| r_busy | input | 1 | Right busy; blocks writes and flag actions |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right registered read data |
| r_irq_n | output | 1 | Right doorbell, active low |

## Verification
The bench acknowledges the left doorbell with write select high. A design that decodes the acknowledge only on reads would leave `l_irq_n` stuck low there. The bench also rings and acknowledges the same flag in one cycle, which catches a design that lets the clear win. It writes each side's own mailbox to check that the doorbell has a direction: a swapped decode would raise the wrong flag. Busy cycles check that neither the stored word nor either flag moves. Same-cycle collisions check that a design storing the left data, or forwarding new data into a read, is caught.

// File: rtl/mbox_dpram_pkg.sv
package mbox_dpram_pkg;

  localparam int unsigned WORD_W_DEF = 9;

  // All-ones address: the mailbox that rings the right side.
  function automatic int unsigned top_addr(input int unsigned aw);
    return (32'd1 << aw) - 32'd1;
  endfunction

  // One below the top: the mailbox that rings the left side.
  function automatic int unsigned below_top_addr(input int unsigned aw);
    return top_addr(aw) - 32'd1;
  endfunction

endpackage

// File: rtl/mbox_dpram_mem.sv
module mbox_dpram_mem #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_we,
  input  logic          a_re,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic          b_re,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  // Side b is written after side a, so b wins a same-word collision.
  always_ff @(posedge clk) begin
    if (a_we) store[a_addr] <= a_wdata;
    if (b_we) store[b_addr] <= b_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_re) a_rdata <= store[a_addr];
      if (b_re) b_rdata <= store[b_addr];
    end
  end
endmodule

// File: rtl/mbox_dpram_port.sv
module mbox_dpram_port #(
  parameter int unsigned AW        = 8,
  parameter logic [AW-1:0] RING_AT = '1,
  parameter logic [AW-1:0] ACK_AT  = '0
) (
  input  logic          en,
  input  logic          wr,
  input  logic          oe,
  input  logic          busy,
  input  logic [AW-1:0] addr,
  output logic          we,
  output logic          re,
  output logic          ring_ev,
  output logic          ack_ev
);
  always_comb begin
    we      = en && wr && !busy;
    re      = en && !wr && oe;
    ring_ev = we && (addr == RING_AT);
    ack_ev  = en && oe && !busy && (addr == ACK_AT);
  end
endmodule

// File: rtl/mbox_dpram_flag.sv
module mbox_dpram_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  output logic irq_n
);
  always_ff @(posedge clk) begin
    if (!rst_n)      irq_n <= 1'b1;
    else if (set_ev) irq_n <= 1'b0;
    else if (clr_ev) irq_n <= 1'b1;
  end
endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = mbox_dpram_pkg::WORD_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_en,
  input  logic              l_wr,
  input  logic              l_oe,
  input  logic              l_busy,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_irq_n,
  input  logic              r_en,
  input  logic              r_wr,
  input  logic              r_oe,
  input  logic              r_busy,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_irq_n
);
  localparam logic [ADDR_W-1:0] MB_TO_R = ADDR_W'(mbox_dpram_pkg::top_addr(ADDR_W));
  localparam logic [ADDR_W-1:0] MB_TO_L = ADDR_W'(mbox_dpram_pkg::below_top_addr(ADDR_W));

  // Index 0 = left side, 1 = right side.
  logic [1:0] we_s, re_s, ring_s, ack_s;
  logic [1:0] irq_n_s;

  mbox_dpram_port #(.AW(ADDR_W), .RING_AT(MB_TO_R), .ACK_AT(MB_TO_L)) port_l_i (
    .en(l_en), .wr(l_wr), .oe(l_oe), .busy(l_busy), .addr(l_addr),
    .we(we_s[0]), .re(re_s[0]), .ring_ev(ring_s[0]), .ack_ev(ack_s[0])
  );

  mbox_dpram_port #(.AW(ADDR_W), .RING_AT(MB_TO_L), .ACK_AT(MB_TO_R)) port_r_i (
    .en(r_en), .wr(r_wr), .oe(r_oe), .busy(r_busy), .addr(r_addr),
    .we(we_s[1]), .re(re_s[1]), .ring_ev(ring_s[1]), .ack_ev(ack_s[1])
  );

  mbox_dpram_mem #(.AW(ADDR_W), .DW(DATA_W)) mem_i (
    .clk(clk), .rst_n(rst_n),
    .a_we(we_s[0]), .a_re(re_s[0]), .a_addr(l_addr), .a_wdata(l_wdata), .a_rdata(l_rdata),
    .b_we(we_s[1]), .b_re(re_s[1]), .b_addr(r_addr), .b_wdata(r_wdata), .b_rdata(r_rdata)
  );

  // Each side's flag is set by the opposite side's ring and cleared by its own ack.
  for (genvar g = 0; g < 2; g++) begin : g_flag
    mbox_dpram_flag flag_i (
      .clk(clk), .rst_n(rst_n),
      .set_ev(ring_s[1-g]), .clr_ev(ack_s[g]),
      .irq_n(irq_n_s[g])
    );
  end

  assign l_irq_n = irq_n_s[0];
  assign r_irq_n = irq_n_s[1];
endmodule

// File: rtl/mbox_dpram_chk.sv
module mbox_dpram_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              l_en,
  input logic              l_wr,
  input logic              l_oe,
  input logic              l_busy,
  input logic [ADDR_W-1:0] l_addr,
  input logic [DATA_W-1:0] l_rdata,
  input logic              l_irq_n,
  input logic              r_en,
  input logic              r_wr,
  input logic              r_oe,
  input logic              r_busy,
  input logic [ADDR_W-1:0] r_addr,
  input logic [DATA_W-1:0] r_rdata,
  input logic              r_irq_n
);
  localparam logic [ADDR_W-1:0] TOP = '1;
  localparam logic [ADDR_W-1:0] TOP_M1 = TOP - 1'b1;

  logic l_rings, r_rings, l_acks, r_acks, l_reads, r_reads;
  assign l_rings = l_en && l_wr && !l_busy && (l_addr == TOP);
  assign r_rings = r_en && r_wr && !r_busy && (r_addr == TOP_M1);
  assign l_acks  = l_en && l_oe && !l_busy && (l_addr == TOP_M1);
  assign r_acks  = r_en && r_oe && !r_busy && (r_addr == TOP);
  assign l_reads = l_en && !l_wr && l_oe;
  assign r_reads = r_en && !r_wr && r_oe;

  // R3, R8: a right ring always leaves the left flag set.
  a_r3_left_set: assert property (@(posedge clk) disable iff (!rst_n)
    r_rings |=> !l_irq_n);
  // R4
  a_r4_left_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (l_acks && !r_rings) |=> l_irq_n);
  // R5
  a_r5_right_set: assert property (@(posedge clk) disable iff (!rst_n)
    l_rings |=> !r_irq_n);
  a_r5_right_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (r_acks && !l_rings) |=> r_irq_n);
  // R9 (and R7: a busy side produces neither event)
  a_r9_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_rings && !l_acks) |=> $stable(l_irq_n));
  a_r9_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_rings && !r_acks) |=> $stable(r_irq_n));
  // R2
  a_r2_left_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !l_reads |=> $stable(l_rdata));
  a_r2_right_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !r_reads |=> $stable(r_rdata));
endmodule

bind mbox_dpram mbox_dpram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .l_en(l_en), .l_wr(l_wr), .l_oe(l_oe), .l_busy(l_busy), .l_addr(l_addr),
  .l_rdata(l_rdata), .l_irq_n(l_irq_n),
  .r_en(r_en), .r_wr(r_wr), .r_oe(r_oe), .r_busy(r_busy), .r_addr(r_addr),
  .r_rdata(r_rdata), .r_irq_n(r_irq_n)
);

// File: tb/mbox_dpram_tb_top.sv
module mbox_dpram_tb_top;
  localparam int AW = 8;
  localparam int DW = 9;
  localparam int TOPA = (1 << AW) - 1;   // R12: all ones
  localparam int LMB  = TOPA - 1;        // R12: one below

  logic clk = 1'b0;
  always #10 clk = ~clk;                 // 50 MHz

  logic rst_n;
  logic l_en, l_wr, l_oe, l_busy, r_en, r_wr, r_oe, r_busy;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_irq_n, r_irq_n;

  int n_run = 0;
  int n_fail = 0;

  mbox_dpram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .l_en(l_en), .l_wr(l_wr), .l_oe(l_oe), .l_busy(l_busy), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
    .r_en(r_en), .r_wr(r_wr), .r_oe(r_oe), .r_busy(r_busy), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
  );

  // Behavioural reference model
  logic [DW-1:0] m_mem [int];
  logic [DW-1:0] m_lq, m_rq;
  logic m_lirq, m_rirq;

  task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    check(tag, "l_irq_n", DW'(l_irq_n), DW'(m_lirq));
    check(tag, "r_irq_n", DW'(r_irq_n), DW'(m_rirq));
    check(tag, "l_rdata", l_rdata, m_lq);
    check(tag, "r_rdata", r_rdata, m_rq);
  endtask

  task automatic drive_l(logic en, logic wr, logic oe, logic bz, int a, int d);
    l_en = en; l_wr = wr; l_oe = oe; l_busy = bz; l_addr = AW'(a); l_wdata = DW'(d);
  endtask

  task automatic drive_r(logic en, logic wr, logic oe, logic bz, int a, int d);
    r_en = en; r_wr = wr; r_oe = oe; r_busy = bz; r_addr = AW'(a); r_wdata = DW'(d);
  endtask

  task automatic idle_both();
    drive_l(0, 0, 0, 0, 0, 0);
    drive_r(0, 0, 0, 0, 0, 0);
  endtask

  // Advance one clock: model next state from the applied inputs, then compare.
  task automatic tick(string tag);
    bit l_set, l_clr, r_set, r_clr;
    int la, ra;
    la = int'(l_addr); ra = int'(r_addr);
    if (l_en && !l_wr && l_oe) m_lq = m_mem.exists(la) ? m_mem[la] : 'x;
    if (r_en && !r_wr && r_oe) m_rq = m_mem.exists(ra) ? m_mem[ra] : 'x;
    l_set = r_en && r_wr && !r_busy && ra == LMB;
    l_clr = l_en && l_oe && !l_busy && la == LMB;
    r_set = l_en && l_wr && !l_busy && la == TOPA;
    r_clr = r_en && r_oe && !r_busy && ra == TOPA;
    if (l_set) m_lirq = 1'b0; else if (l_clr) m_lirq = 1'b1;
    if (r_set) m_rirq = 1'b0; else if (r_clr) m_rirq = 1'b1;
    if (l_en && l_wr && !l_busy) m_mem[la] = l_wdata;
    if (r_en && r_wr && !r_busy) m_mem[ra] = r_wdata;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : stim
    rst_n = 1'b0;
    idle_both();
    m_lq = '0; m_rq = '0; m_lirq = 1'b1; m_rirq = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;

    // R2: basic writes and cross-side reads
    drive_l(1, 1, 0, 0, 5, 'h1A5); drive_r(1, 1, 0, 0, 6, 'h0C3); tick("R2");
    drive_l(1, 0, 1, 0, 6, 0);     drive_r(1, 0, 1, 0, 5, 0);     tick("R2");
    idle_both(); tick("R9");
    drive_l(1, 0, 0, 0, 5, 0); tick("R2");          // oe low: data holds

    // R5 and R6: ring the right side
    idle_both(); drive_l(1, 1, 0, 0, TOPA, 'h155); tick("R5");
    drive_l(1, 0, 1, 0, TOPA, 0); tick("R5");        // left access of top: no clear
    idle_both(); drive_r(1, 1, 0, 0, TOPA, 'h033); drive_r(0, 0, 0, 0, 0, 0); tick("R9");
    drive_r(1, 0, 1, 0, TOPA, 0); tick("R6");       // clear + message readback
    idle_both(); drive_r(1, 1, 0, 0, TOPA, 'h0F0); tick("R5");   // own mailbox: no set

    // R3, R4: ring the left side
    idle_both(); drive_r(1, 1, 0, 0, LMB, 'h0AA); tick("R3");
    idle_both(); drive_l(1, 0, 0, 0, LMB, 0); tick("R4");        // oe low: no clear
    drive_l(1, 1, 1, 0, LMB, 'h111); tick("R4");                 // write select ignored
    idle_both(); drive_r(1, 0, 1, 0, LMB, 0); tick("R6");
    idle_both(); drive_l(1, 1, 0, 0, LMB, 'h122); tick("R3");    // own mailbox: no set

    // R7: busy blocks writes, sets and clears
    idle_both(); drive_r(1, 1, 0, 1, LMB, 'h1FF); tick("R7");
    idle_both(); drive_r(1, 0, 1, 0, LMB, 0); tick("R7");
    idle_both(); drive_r(1, 1, 0, 0, LMB, 'h044); tick("R3");
    idle_both(); drive_l(1, 0, 1, 1, LMB, 0); tick("R7");
    drive_l(1, 0, 1, 0, LMB, 0); tick("R4");

    // R8: set and clear together, set wins; R11 read sees old data
    idle_both(); drive_r(1, 1, 0, 0, LMB, 'h066); drive_l(1, 0, 1, 0, LMB, 0); tick("R8");
    idle_both(); drive_l(1, 0, 1, 0, LMB, 0); tick("R4");
    idle_both(); drive_l(1, 1, 0, 0, TOPA, 'h077); drive_r(1, 0, 1, 0, TOPA, 0); tick("R8");
    idle_both(); drive_r(1, 0, 1, 0, TOPA, 0); tick("R6");

    // R10: same-word write collision
    idle_both(); drive_l(1, 1, 0, 0, 9, 'h101); drive_r(1, 1, 0, 0, 9, 'h0BE); tick("R10");
    idle_both(); drive_l(1, 0, 1, 0, 9, 0); tick("R10");

    // R11: read during other side's write to same word
    idle_both(); drive_l(1, 1, 0, 0, 10, 'h0D1); tick("R2");
    drive_l(1, 1, 0, 0, 10, 'h1E2); drive_r(1, 0, 1, 0, 10, 0); tick("R11");
    idle_both(); drive_r(1, 0, 1, 0, 10, 0); tick("R11");
    idle_both(); tick("R9");

    // R1 again: reset mid-run restores flags and read data
    drive_r(1, 1, 0, 0, LMB, 'h012); tick("R3");
    idle_both(); rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    m_lirq = 1'b1; m_rirq = 1'b1; m_lq = '0; m_rq = '0;
    compare("R1");
    rst_n = 1'b1;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule